// File: doc/BRIEF.md
# Gated Pulse Frequency Meter

This block measures the rate of an asynchronous pulse train for a small controller. A divider turns the system clock into a slow timebase (10 Hz from 12 MHz by default). Each measurement spans two timebase periods. In the first period the pulse counter is cleared while the timebase is low. In the second period it counts every rising edge of the measured input. At the next timebase rising edge the count is copied into a result register and an interrupt is raised.

The controller answers the interrupt by stepping a 3-bit select input and reading the 32-bit result one byte at a time over an 8-bit bus. The result register holds its value while the next count is already running. The measured input is brought into the clock domain through a two-stage synchronizer with edge detection. Its rate must therefore stay below half the system clock.

Top module: `fm_gated_meter`

## Requirements
- R1: While reset is low and after it is released, the interrupt output is 0 and every select value reads 0 on the data bus, until the first latch.
- R2: The timebase period is 2*HALF_CYC system clocks, with HALF_CYC = CLK_HZ/(2*TB_HZ). A latch occurs on every second timebase rising edge, so interrupt rising edges are exactly 4*HALF_CYC clocks apart.
- R3: The latched result equals the number of measured-input rising edges during a counting window of exactly 2*HALF_CYC clocks, within one count.
- R4: The interrupt rises in the cycle the result is latched and stays high for exactly HALF_CYC clocks. It falls when the timebase drops in the non-counting period, which is when the counter clear begins.
- R5: Select values 0, 1, 2 and 3 put result bits [7:0], [15:8], [23:16] and [31:24] on the data bus.
- R6: Select values 4 to 7 put 0 on the data bus.
- R7: The result register keeps its value from one latch to the next, including while the following count runs.
- R8: The counter is cleared before each counting window, so a measurement with no input edges reads exactly 0.
- R9: Asserting reset in the middle of a measurement abandons it. After release, the first interrupt rises 4*HALF_CYC clocks later, plus at most four clocks of reset synchronization.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset from the controller |
| meas_i | input | 1 | Asynchronous measured pulse input |
| sel_i | input | 3 | Byte select for the readout bus |
| data_o | output | 8 | Selected result byte |
| irq_o | output | 1 | Result-ready interrupt |

## Verification
The counting function is driven with a 20 ns pulse period, which gives a count above 255 and exercises the middle result byte. It is also driven with a slow 80 ns period, with an idle input that must read exactly zero, and with seeded random periods that have fractional nanoseconds. Those fractional periods slide the input edges across the clock grid and show whether the counting window is off by more than one edge. Each run also measures the interrupt spacing and pulse width in clocks, which separates a correct two-period cycle from a one-period one. A reset asserted in the middle of a count shows whether the sequence restarts cleanly rather than latching a partial value.

// File: rtl/fm_pkg.sv
package fm_pkg;
  // Timebase events handed from the divider to the gate sequencer.
  typedef struct packed {
    logic rise;   // last clock of the period: timebase rises at the next edge
    logic fall;   // last clock of the high half: timebase falls at the next edge
    logic high;   // timebase level
  } tb_evt_t;
endpackage

// File: rtl/fm_rst_sync.sv
module fm_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/fm_timebase.sv
module fm_timebase #(
  parameter int HALF_CYC = 600000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output fm_pkg::tb_evt_t evt_o
);
  localparam int PER_CYC = 2 * HALF_CYC;
  localparam int CW      = $clog2(PER_CYC);
  localparam logic [CW-1:0] LAST  = CW'(PER_CYC - 1);
  localparam logic [CW-1:0] HLAST = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] HALF  = CW'(HALF_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign evt_o.rise = (cnt_q == LAST);
  assign evt_o.fall = (cnt_q == HLAST);
  assign evt_o.high = (cnt_q < HALF);

  assert_rise_in_low_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.rise |-> !evt_o.high);
  assert_high_after_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.rise |=> evt_o.high);
endmodule

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q, pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-1:0], async_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  // The oldest stage holds the previous synchronized level.
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/fm_gate_counter.sv
module fm_gate_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  fm_pkg::tb_evt_t  tb_i,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] result_o,
  output logic             irq_o
);
  logic             en_q, en_d;
  logic             load_q, load_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] res_q, res_d;
  logic             irq_q, irq_d;
  logic             latch;

  assign latch = tb_i.rise & en_q;

  always_comb begin
    en_d   = en_q;
    load_d = load_q;
    if (tb_i.rise) begin
      en_d   = ~en_q;
      load_d = en_q;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load_q && !tb_i.high)  cnt_d = '0;
    else if (en_q && pulse_i)  cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    res_d = latch ? cnt_q : res_q;
    irq_d = irq_q;
    if (latch)                     irq_d = 1'b1;
    else if (tb_i.fall && load_q)  irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      load_q <= 1'b1;
      cnt_q  <= '0;
      res_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      load_q <= load_d;
      cnt_q  <= cnt_d;
      res_q  <= res_d;
      irq_q  <= irq_d;
    end
  end

  assign result_o = res_q;
  assign irq_o    = irq_q;

  assert_phase_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q != load_q);
  assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
  assert_irq_on_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch |=> irq_o && (result_o == $past(cnt_q)));
  assert_irq_low_while_counting_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> !irq_o);
  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch |=> $stable(result_o));
  assert_cleared_before_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tb_i.rise && !en_q) |-> cnt_q == '0);
endmodule

// File: rtl/fm_gated_meter.sv
module fm_gated_meter #(
  parameter int CLK_HZ   = 12000000,
  parameter int TB_HZ    = 10,
  parameter int HALF_CYC = CLK_HZ / (2 * TB_HZ),
  parameter int CNT_W    = 32,
  parameter int BUS_W    = 8,
  parameter int SEL_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [BUS_W-1:0] data_o,
  output logic             irq_o
);
  localparam int NBYTES = CNT_W / BUS_W;
  localparam int IW     = $clog2(NBYTES);

  logic             rst_n;
  fm_pkg::tb_evt_t  tb_evt;
  logic             pulse;
  logic [CNT_W-1:0] result;
  logic [BUS_W-1:0] slice [NBYTES];

  fm_rst_sync u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  fm_timebase #(.HALF_CYC(HALF_CYC)) u_tb (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .evt_o (tb_evt)
  );

  fm_edge_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .async_i(meas_i),
    .rise_o (pulse)
  );

  fm_gate_counter #(.CNT_W(CNT_W)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .tb_i    (tb_evt),
    .pulse_i (pulse),
    .result_o(result),
    .irq_o   (irq_o)
  );

  for (genvar b = 0; b < NBYTES; b++) begin : g_slice
    assign slice[b] = result[b*BUS_W +: BUS_W];
  end

  always_comb begin
    if (sel_i < SEL_W'(NBYTES)) data_o = slice[sel_i[IW-1:0]];
    else                        data_o = '0;
  end

  assert_sel_out_of_range_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sel_i >= SEL_W'(NBYTES)) |-> data_o == '0);
  assert_sel_low_byte_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sel_i == '0) |-> data_o == result[BUS_W-1:0]);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_n |-> !irq_o);
endmodule

// File: tb/fm_gated_meter_tb_top.sv
`timescale 1ns/1ps
module fm_gated_meter_tb_top;
  localparam int  HALF   = 2000;
  localparam real CLK_NS = 8.0;
  localparam real GATE_NS = 2.0 * HALF * CLK_NS;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       meas_i = 1'b0;
  logic [2:0] sel_i = 3'd0;
  logic [7:0] data_o;
  logic       irq_o;

  int  n_chk = 0;
  int  n_bad = 0;
  real half_ns = 0.0;

  fm_gated_meter #(.CLK_HZ(40000), .TB_HZ(10)) dut_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .meas_i(meas_i),
    .sel_i (sel_i),
    .data_o(data_o),
    .irq_o (irq_o)
  );

  always #4 clk_i = ~clk_i;

  // Measured pulse source, half period given in ns; 0 holds the line low.
  initial begin
    forever begin
      if (half_ns == 0.0) begin
        meas_i = 1'b0;
        #5;
      end else begin
        meas_i = ~meas_i;
        #(half_ns);
      end
    end
  end

  // Interrupt timing monitor.
  int   cyc = 0;
  int   rise_at = 0;
  int   spacing = 0;
  int   hi_len = 0;
  int   rise_cnt = 0;
  int   fall_cnt = 0;
  logic irq_prev = 1'b0;
  always @(negedge clk_i) begin
    cyc = cyc + 1;
    if (irq_o && !irq_prev) begin
      spacing  = cyc - rise_at;
      rise_at  = cyc;
      rise_cnt = rise_cnt + 1;
    end
    if (!irq_o && irq_prev) begin
      hi_len   = cyc - rise_at;
      fall_cnt = fall_cnt + 1;
    end
    irq_prev = irq_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic real expect_cnt(input real hns);
    if (hns == 0.0) return 0.0;
    return GATE_NS / (2.0 * hns);
  endfunction

  task automatic read_all(output logic [31:0] v);
    for (int b = 0; b < 4; b++) begin
      sel_i = 3'(b);
      #1;
      v[b*8 +: 8] = data_o;
    end
    sel_i = 3'd0;
  endtask

  task automatic wait_rise();
    int n = rise_cnt;
    while (rise_cnt == n) begin
      @(negedge clk_i);
      #1;
    end
  endtask

  task automatic wait_fall();
    int n = fall_cnt;
    while (fall_cnt == n) begin
      @(negedge clk_i);
      #1;
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
    #1;
  endtask

  task automatic check_count(input string req, input real hns, input logic [31:0] got);
    real e = expect_cnt(hns);
    real d = real'(got) - e;
    if (d < 0.0) d = -d;
    chk(d <= 1.001, req, "latched count", longint'(got), longint'(e));
  endtask

  // Watchdog
  initial begin
    #(190000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    real         cur;
    real         nxt;
    int unsigned seed;
    int          start;

    seed = $urandom(32'd20240611);
    wait_clk(3);
    // R1: reset state
    chk(irq_o == 1'b0, "R1", "irq in reset", irq_o, 0);
    for (int s = 0; s < 8; s++) begin
      sel_i = 3'(s);
      #1;
      chk(data_o == 8'h00, "R1", "byte in reset", data_o, 0);
    end
    cur = 40.0;          // 80 ns period
    half_ns = cur;
    rst_ni = 1'b1;
    wait_clk(10);
    read_all(v);
    chk(v == 32'd0 && irq_o == 1'b0, "R1", "result after release", v, 0);

    wait_rise();
    read_all(v);
    check_count("R3", cur, v);

    for (int it = 0; it < 8; it++) begin
      if (it == 0)      nxt = 10.0;   // 20 ns period, count near 1600
      else if (it == 1) nxt = 0.0;    // idle input
      else              nxt = 10.0 + real'($urandom % 1000) / 10.0;
      half_ns = nxt;
      cur = nxt;
      wait_fall();
      chk(hi_len == HALF, "R4", "irq high length", hi_len, HALF);
      wait_rise();
      chk(spacing == 4 * HALF, "R2", "irq spacing", spacing, 4 * HALF);
      read_all(v);
      if (cur == 0.0) chk(v == 32'd0, "R8", "idle count", v, 0);
      else            check_count("R3", cur, v);
      if (it == 0) begin
        chk(v[31:8] == 24'd6, "R5", "upper bytes", v[31:8], 6);
        for (int s = 4; s < 8; s++) begin
          sel_i = 3'(s);
          #1;
          chk(data_o == 8'h00, "R6", "out of range select", data_o, 0);
        end
        sel_i = 3'd0;
      end
      // R7: hold while the next count runs
      wait_clk(2 * HALF + 500);
      chk(irq_o == 1'b0, "R4", "irq low during count", irq_o, 0);
      read_all(v2);
      chk(v2 == v, "R7", "result held", v2, v);
    end

    // R9: reset in mid count
    half_ns = 20.0;
    cur = 20.0;
    wait_clk(300);
    rst_ni = 1'b0;
    wait_clk(4);
    read_all(v);
    chk(v == 32'd0 && irq_o == 1'b0, "R9", "cleared by reset", v, 0);
    rst_ni = 1'b1;
    start = cyc;
    wait_rise();
    chk((rise_at - start) >= 4 * HALF && (rise_at - start) <= 4 * HALF + 4,
        "R9", "first irq delay", rise_at - start, 4 * HALF);
    read_all(v);
    check_count("R9", cur, v);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule